// File: doc/BRIEF.md
# Pipeline Structural Hazard Controller

This block resolves resource conflicts for a five-stage in-order pipeline (fetch, decode with register read, execute, memory, write-back). Instruction fetch and data loads and stores share one single-port memory, and the register file has only one write port. The controller receives the class of the instruction offered for fetch each cycle. It follows each admitted instruction's class through its own stage record. From that record it decides who owns the memory port, when fetch must hold, and when the register file is written.

When a load or store reaches the memory stage, that access wins the port. A fetch requested in the same cycle is held: the program counter must not advance, and an empty slot enters decode instead of an instruction. R-type instructions are not allowed to retire early. They pass through an idle memory stage so that every writer reaches the register write port in its fifth stage. Two writes can therefore never collide. A stall counter records the fetch cycles lost to port conflicts.

Top module: `hazard_issue_ctrl`

## Requirements
- R1: Class codes on `fetch_cls` are 0 = empty/no-op, 1 = R-type, 2 = load, 3 = store, 4 = branch. Codes 5 to 7 behave like a branch: no data access and no register write. An instruction admitted at a clock edge (`fetch_go` high) occupies the memory stage during the third cycle after that edge and the write-back stage during the fourth.
- R2: While a load or store is in the memory stage, `port_sel` is 1 and `mem_en` is 1. `mem_we` is 1 only for a store. A data access and a granted fetch never share a cycle.
- R3: When `fetch_req` is high while a load or store is in the memory stage, `fetch_go` is 0 and `fetch_stall` is 1. `fetch_go` is the only program-counter advance strobe, so the fetch address is held.
- R4: `bubble_ins` is 1 in every stall cycle. The slot it inserts causes no data access and no register write in later cycles.
- R5: With no load or store in the memory stage, `port_sel` is 0, `fetch_go` equals `fetch_req`, and `mem_en` equals `fetch_req`.
- R6: A valid instruction of any class other than load or store that is in the memory stage raises `mem_idle` and does not take the memory port.
- R7: `rf_we` is 1 exactly when the write-back stage holds an admitted R-type or load. An R-type fetched one cycle after a load writes one cycle after it, never in the same cycle.
- R8: Register write-back never causes a fetch stall. Only a data access in the memory stage can hold fetch.
- R9: `stall_cnt` is 0 after reset. It increases by one in each cycle with `fetch_stall` high and saturates at 2^CNT_W-1.
- R10: Reset empties all stages: no data access, no register write and no idle-stage indication until newly admitted instructions arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | An instruction is offered for fetch this cycle |
| fetch_cls | input | 3 | Class of the offered instruction |
| fetch_go | output | 1 | Fetch uses the memory port; the program counter advances |
| fetch_stall | output | 1 | Requested fetch is held this cycle |
| bubble_ins | output | 1 | An empty slot enters decode at the next edge |
| port_sel | output | 1 | Memory port owner: 1 = data access, 0 = fetch |
| mem_en | output | 1 | Memory port enabled this cycle |
| mem_we | output | 1 | Memory port write (store) |
| mem_idle | output | 1 | Valid instruction passes the memory stage without access |
| rf_we | output | 1 | Register file write-port enable |
| stall_cnt | output | CNT_W | Saturating count of stalled fetch cycles |

## Verification
On every cycle, the assertions check several properties. The port is never owned by fetch and data at once, and a stall always coincides with data ownership. Port ownership and register writes must match the classes admitted three and four edges earlier. The stall counter must step or saturate correctly. Only the bench's replayed sequences can show that the whole schedule is right over long mixtures of classes and idle requests. These include back-to-back loads and stores, an R-type directly behind a load, stalls that cascade into later stalls, and a reset in mid-stream.

// File: rtl/hazard_issue_ctrl.sv
module hazard_issue_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req,
  input  logic [2:0]       fetch_cls,
  output logic             fetch_go,
  output logic             fetch_stall,
  output logic             bubble_ins,
  output logic             port_sel,
  output logic             mem_en,
  output logic             mem_we,
  output logic             mem_idle,
  output logic             rf_we,
  output logic [CNT_W-1:0] stall_cnt
);
  localparam logic [2:0] CLS_RTYPE = 3'd1;
  localparam logic [2:0] CLS_LOAD  = 3'd2;
  localparam logic [2:0] CLS_STORE = 3'd3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       v_id, v_ex, v_mem, v_wb;
  logic [2:0] c_id, c_ex, c_mem, c_wb;
  logic       data_acc;

  assign data_acc    = v_mem && (c_mem == CLS_LOAD || c_mem == CLS_STORE);
  assign port_sel    = data_acc;
  assign fetch_go    = fetch_req && !data_acc;
  assign fetch_stall = fetch_req && data_acc;
  assign bubble_ins  = fetch_stall;
  assign mem_en      = data_acc || fetch_go;
  assign mem_we      = v_mem && c_mem == CLS_STORE;
  assign mem_idle    = v_mem && !data_acc;
  assign rf_we       = v_wb && (c_wb == CLS_RTYPE || c_wb == CLS_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_id <= 1'b0; v_ex <= 1'b0; v_mem <= 1'b0; v_wb <= 1'b0;
      c_id <= '0;   c_ex <= '0;   c_mem <= '0;   c_wb <= '0;
      stall_cnt <= '0;
    end else begin
      v_id  <= fetch_go;
      c_id  <= fetch_go ? fetch_cls : 3'd0;
      v_ex  <= v_id;   c_ex  <= c_id;
      v_mem <= v_ex;   c_mem <= c_ex;
      v_wb  <= v_mem;  c_wb  <= c_mem;
      if (fetch_stall && stall_cnt != CNT_MAX) stall_cnt <= stall_cnt + 1'b1;
    end
  end
endmodule

module hazard_issue_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req,
  input logic [2:0]       fetch_cls,
  input logic             fetch_go,
  input logic             fetch_stall,
  input logic             bubble_ins,
  input logic             port_sel,
  input logic             mem_en,
  input logic             mem_we,
  input logic             mem_idle,
  input logic             rf_we,
  input logic [CNT_W-1:0] stall_cnt
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_sel && fetch_go));

  // R2
  port_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> mem_en);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (port_sel && !fetch_go));

  // R4
  bubble_with_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ins |-> fetch_stall);

  // R6
  idle_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_idle |-> !port_sel);

  // R1
  mem_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3) |-> (port_sel == ($past(fetch_go, 3) &&
      ($past(fetch_cls, 3) == 3'd2 || $past(fetch_cls, 3) == 3'd3))));

  // R7
  wb_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4) |-> (rf_we == ($past(fetch_go, 4) &&
      ($past(fetch_cls, 4) == 3'd1 || $past(fetch_cls, 4) == 3'd2))));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 3'd3) |-> (!port_sel && !mem_idle && !rf_we));

  // R9
  stall_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1) |-> (stall_cnt == (($past(fetch_stall) && $past(stall_cnt) != {CNT_W{1'b1}})
      ? $past(stall_cnt) + 1'b1 : $past(stall_cnt))));
endmodule

bind hazard_issue_ctrl hazard_issue_ctrl_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_hazard_issue_ctrl.sv
module test_hazard_issue_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0;
  logic [2:0] fetch_cls = 3'd0;
  logic fetch_go, fetch_stall, bubble_ins, port_sel, mem_en, mem_we, mem_idle, rf_we;
  logic [CW-1:0] stall_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic       h_go [1:4];
  logic [2:0] h_cls[1:4];
  int exp_cnt = 0;

  hazard_issue_ctrl #(.CNT_W(CW)) i_hazard_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_cls(fetch_cls),
    .fetch_go(fetch_go), .fetch_stall(fetch_stall), .bubble_ins(bubble_ins),
    .port_sel(port_sel), .mem_en(mem_en), .mem_we(mem_we), .mem_idle(mem_idle),
    .rf_we(rf_we), .stall_cnt(stall_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_hist();
    for (int k = 1; k <= 4; k++) begin h_go[k] = 1'b0; h_cls[k] = 3'd0; end
    exp_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; fetch_req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    clear_hist();
    #1;
    chk("R10 rf_we after reset", int'(rf_we), 0);
    chk("R10 port_sel after reset", int'(port_sel), 0);
    chk("R10 mem_idle after reset", int'(mem_idle), 0);
    chk("R9 stall_cnt after reset", int'(stall_cnt), 0);
  endtask

  task automatic step(logic req, logic [2:0] cls);
    logic acc, st, wr, idle, go;
    @(negedge clk);
    fetch_req = req; fetch_cls = cls;
    #1;
    acc  = h_go[3] && (h_cls[3] == 3'd2 || h_cls[3] == 3'd3);
    st   = h_go[3] && h_cls[3] == 3'd3;
    idle = h_go[3] && !acc;
    wr   = h_go[4] && (h_cls[4] == 3'd1 || h_cls[4] == 3'd2);
    go   = req && !acc;
    chk("R2 port_sel", int'(port_sel), int'(acc));
    chk("R2 mem_we", int'(mem_we), int'(st));
    chk("R5 mem_en", int'(mem_en), int'(acc || go));
    chk("R3 fetch_go", int'(fetch_go), int'(go));
    chk("R3 fetch_stall", int'(fetch_stall), int'(req && acc));
    chk("R4 bubble_ins", int'(bubble_ins), int'(req && acc));
    chk("R6 mem_idle", int'(mem_idle), int'(idle));
    chk("R7 rf_we", int'(rf_we), int'(wr));
    chk("R9 stall_cnt", int'(stall_cnt), exp_cnt);
    if (req && acc && exp_cnt < CMAX) exp_cnt++;
    for (int k = 4; k > 1; k--) begin h_go[k] = h_go[k-1]; h_cls[k] = h_cls[k-1]; end
    h_go[1] = go; h_cls[1] = go ? cls : 3'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_hist();
    do_reset();
    // R1 R7: load then R-type back to back, write-backs one cycle apart
    step(1, 3'd2); step(1, 3'd1); step(1, 3'd0); step(1, 3'd0);
    step(1, 3'd0); step(1, 3'd0); step(0, 3'd0); step(0, 3'd0);
    // R1..R8: every 4-tuple of classes 0..4 with steady requests
    for (int i = 0; i < 625; i++) begin
      step(1, 3'((i / 125) % 5)); step(1, 3'((i / 25) % 5));
      step(1, 3'((i / 5) % 5));   step(1, 3'(i % 5));
    end
    // R9 saturation reached above; R10 mid-stream reset
    do_reset();
    // R1 R5 R6: all eight codes with gapped request patterns
    for (int i = 0; i < 512; i++) begin
      step(((i * 5) % 7) != 0, 3'(i % 8));
      step((i % 3) != 1, 3'((i / 8) % 8));
    end
    for (int i = 0; i < 8; i++) step(0, 3'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule